// File: doc/BRIEF.md
# Keyboard/Mouse Controller Host Register Interface

This block is the host-facing side of a keyboard and mouse controller that follows the classic two-port layout. It is built as plain state logic with no embedded processor. The host sees two byte-wide ports, selected by one address line. The data port (60h) is read to collect a byte that the device side has delivered, and written to pass a data byte inward. The status/command port (64h) is read for an 8-bit status word and written to pass a command byte inward.

On the device side, a loader places a received byte into the output buffer, together with a tag that says whether it came from the keyboard or from the mouse. If the buffer is still full, the load is refused and a stall is signalled. On the controller side, a consumer reads the input buffer and then releases it. That consumer sees whether the pending byte was written as a command or as data. The status word also carries a system flag written by the controller side, the synchronized keyboard-inhibit switch level, and a timeout flag.

Top module: `kbc_host_port`

## Requirements
- R1: After reset the status word (read at port 64h, `host_sel_cmd`=1) is 00h, and status bit 7 reads 0 at all times.
- R2: A `dev_load` into an empty output buffer sets status bit 0 and places `dev_data` at port 60h (`host_sel_cmd`=0). Status bit 5 becomes 1 if `dev_is_aux`=1 (mouse) and 0 otherwise (keyboard).
- R3: A host read of port 60h (`host_rd`=1, `host_sel_cmd`=0) returns the buffered byte in that cycle. Status bits 0 and 5 are both clear from the next clock edge.
- R4: A `dev_load` while status bit 0 is set drives `dev_stall` high in that cycle. The load is refused: the buffered byte and bit 5 are unchanged.
- R5: A host write to either port sets status bit 1 and presents the written byte on `ctl_byte`. Status bit 3 becomes 1 for a write to 64h and 0 for a write to 60h.
- R6: A second host write before the consumer releases the buffer replaces the pending byte.
- R7: A `ctl_take` pulse with no host write clears status bit 1 at the next edge, and bit 3 keeps its value. A host write in the same cycle as `ctl_take` takes priority: bit 1 stays set and the new byte is pending.
- R8: Status bit 2 is loaded from `sys_flag_in` in each cycle where `sys_flag_we`=1, and holds otherwise.
- R9: Status bit 4 follows the level of `inhibit_in` (1 = high) after `SYNC_STAGES` clock edges (default 2). It is unchanged after one edge.
- R10: Status bit 6 is set by `timeout_set` and cleared by `timeout_clr`; when both are high, set wins.
- R11: A host read of port 64h has no side effect. It returns the status word and leaves bits 0, 1 and 5 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_sel_cmd | input | 1 | Port select: 1 = status/command (64h), 0 = data (60h) |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Read value of the selected port |
| dev_load | input | 1 | Device side offers a received byte |
| dev_is_aux | input | 1 | Tag of the offered byte: 1 = mouse, 0 = keyboard |
| dev_data | input | DATA_W | Offered byte |
| dev_stall | output | 1 | Offer refused because the output buffer is full |
| ctl_take | input | 1 | Controller side releases the input buffer |
| ctl_byte | output | DATA_W | Pending host-written byte |
| ctl_is_cmd | output | 1 | Pending byte came through port 64h |
| ctl_pending | output | 1 | Input buffer holds an unconsumed byte |
| sys_flag_we | input | 1 | Load enable for the system flag |
| sys_flag_in | input | 1 | New system flag value |
| inhibit_in | input | 1 | Raw keyboard-inhibit switch level |
| timeout_set | input | 1 | Set the timeout flag |
| timeout_clr | input | 1 | Clear the timeout flag |

## Verification
The output buffer is driven with both a keyboard-tagged byte and a mouse-tagged byte. This separates a correct bit 5 from one that is stuck or inverted. It also shows that a data-port read clears the tag as well as the full flag. A load into a full buffer is offered with a different tag and byte, so that an accepted overwrite shows up at port 60h. The input buffer is exercised with writes to each port, a write that collides with a release, and back-to-back writes. Together these tell the bit 3 origin tracking apart from the pending flag and its priority rule. The inhibit level is sampled after one edge and again after two, which pins the synchronizer depth. The timeout flag is driven with set and clear together.

// File: rtl/kbc_hif_pkg.sv
package kbc_hif_pkg;
   // Status word bit positions (host software decodes these)
   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_SYS = 2;
   localparam int ST_CMD = 3;
   localparam int ST_INH = 4;
   localparam int ST_AUX = 5;
   localparam int ST_TMO = 6;
   localparam int ST_W   = 8;

   typedef struct packed {
      logic tmo;
      logic aux;
      logic inh;
      logic cmd;
      logic sys;
      logic ibf;
      logic obf;
   } stat_bits_t;

   function automatic logic [ST_W-1:0] pack_status(stat_bits_t s);
      logic [ST_W-1:0] v;
      v         = '0;
      v[ST_OBF] = s.obf;
      v[ST_IBF] = s.ibf;
      v[ST_SYS] = s.sys;
      v[ST_CMD] = s.cmd;
      v[ST_INH] = s.inh;
      v[ST_AUX] = s.aux;
      v[ST_TMO] = s.tmo;
      return v;
   endfunction
endpackage

// File: rtl/kbc_lvl_sync.sv
module kbc_lvl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   output logic lvl_out
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad_depth
         $error("kbc_lvl_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_pass
         assign lvl_out = lvl_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= lvl_in;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign lvl_out = chain_q[STAGES-1];

         // R9: the last stage takes the previous stage's value
         a_r9_sync_shift: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> lvl_out == $past(chain_q[STAGES-1 > 0 ? STAGES-2 : 0]) || STAGES == 1)
            else $error("a_r9_sync_shift");
      end
   endgenerate
endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_aux,
   input  logic [DATA_W-1:0] load_data,
   input  logic              host_take,
   output logic              full,
   output logic              aux,
   output logic [DATA_W-1:0] data,
   output logic              stall
);
   logic              full_q, aux_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;

   assign accept = load && !full_q;
   assign stall  = load && full_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         aux_q  <= 1'b0;
         data_q <= '0;
      end else if (accept) begin
         full_q <= 1'b1;
         aux_q  <= load_aux;
         data_q <= load_data;
      end else if (host_take) begin
         full_q <= 1'b0;
         aux_q  <= 1'b0;
      end
   end

   assign full = full_q;
   assign aux  = aux_q;
   assign data = data_q;

   a_r2_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !full) |=> (full && aux == $past(load_aux) && data == $past(load_data)))
      else $error("a_r2_load_fills");
   a_r3_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (host_take && full) |=> (!full && !aux))
      else $error("a_r3_read_empties");
   a_r4_stall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !host_take) |=> ($stable(data) && $stable(aux) && full))
      else $error("a_r4_stall_keeps");
   a_r2_aux_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      aux |-> full)
      else $error("a_r2_aux_needs_full");
endmodule

// File: rtl/kbc_ibuf.sv
module kbc_ibuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              wr_cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   output logic              full,
   output logic              is_cmd,
   output logic [DATA_W-1:0] data
);
   logic              full_q, cmd_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         cmd_q  <= 1'b0;
         data_q <= '0;
      end else if (wr) begin
         full_q <= 1'b1;
         cmd_q  <= wr_cmd;
         data_q <= wdata;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   assign full   = full_q;
   assign is_cmd = cmd_q;
   assign data   = data_q;

   a_r5_write_pends: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (full && is_cmd == $past(wr_cmd) && data == $past(wdata)))
      else $error("a_r5_write_pends");
   a_r7_take_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr) |=> (!full && $stable(is_cmd)))
      else $error("a_r7_take_releases");
endmodule

// File: rtl/kbc_stat_flags.sv
module kbc_stat_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic sys_we,
   input  logic sys_in,
   input  logic tmo_set,
   input  logic tmo_clr,
   output logic sys,
   output logic tmo
);
   logic sys_q, tmo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sys_q <= 1'b0;
         tmo_q <= 1'b0;
      end else begin
         if (sys_we) sys_q <= sys_in;
         if (tmo_set)      tmo_q <= 1'b1;
         else if (tmo_clr) tmo_q <= 1'b0;
      end
   end

   assign sys = sys_q;
   assign tmo = tmo_q;

   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_set |=> tmo)
      else $error("a_r10_set_wins");
   a_r8_sys_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !sys_we |=> $stable(sys))
      else $error("a_r8_sys_holds");
endmodule

// File: rtl/kbc_host_port.sv
module kbc_host_port
   import kbc_hif_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic              host_sel_cmd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              dev_load,
   input  logic              dev_is_aux,
   input  logic [DATA_W-1:0] dev_data,
   output logic              dev_stall,
   input  logic              ctl_take,
   output logic [DATA_W-1:0] ctl_byte,
   output logic              ctl_is_cmd,
   output logic              ctl_pending,
   input  logic              sys_flag_we,
   input  logic              sys_flag_in,
   input  logic              inhibit_in,
   input  logic              timeout_set,
   input  logic              timeout_clr
);
   localparam int PAD_W = DATA_W - ST_W;

   generate
      if (DATA_W < ST_W) begin : g_bad_width
         $error("kbc_host_port: DATA_W must be at least the status width");
      end
   endgenerate

   logic              data_rd;
   logic              ob_full, ob_aux, ib_full, ib_cmd, sys_f, tmo_f, inh_lvl;
   logic [DATA_W-1:0] ob_data;
   stat_bits_t        st;
   logic [ST_W-1:0]   st_word;
   logic [DATA_W-1:0] st_ext;

   assign data_rd = host_rd && !host_sel_cmd;

   kbc_obuf #(.DATA_W(DATA_W)) u_obuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (dev_load),
      .load_aux  (dev_is_aux),
      .load_data (dev_data),
      .host_take (data_rd),
      .full      (ob_full),
      .aux       (ob_aux),
      .data      (ob_data),
      .stall     (dev_stall)
   );

   kbc_ibuf #(.DATA_W(DATA_W)) u_ibuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (host_wr),
      .wr_cmd (host_sel_cmd),
      .wdata  (host_wdata),
      .take   (ctl_take),
      .full   (ib_full),
      .is_cmd (ib_cmd),
      .data   (ctl_byte)
   );

   kbc_stat_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .sys_we  (sys_flag_we),
      .sys_in  (sys_flag_in),
      .tmo_set (timeout_set),
      .tmo_clr (timeout_clr),
      .sys     (sys_f),
      .tmo     (tmo_f)
   );

   kbc_lvl_sync #(.STAGES(SYNC_STAGES)) u_inh_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_in  (inhibit_in),
      .lvl_out (inh_lvl)
   );

   always_comb begin
      st.obf  = ob_full;
      st.ibf  = ib_full;
      st.sys  = sys_f;
      st.cmd  = ib_cmd;
      st.inh  = inh_lvl;
      st.aux  = ob_aux;
      st.tmo  = tmo_f;
      st_word = pack_status(st);
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign st_ext = {{PAD_W{1'b0}}, st_word};
      end else begin : g_nopad
         assign st_ext = st_word;
      end
   endgenerate

   assign host_rdata  = host_sel_cmd ? st_ext : ob_data;
   assign ctl_is_cmd  = ib_cmd;
   assign ctl_pending = ib_full;

   // R11: status reads leave buffer state alone
   a_r11_status_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_sel_cmd && !host_wr && !dev_load && !ctl_take)
      |=> ($stable(ob_full) && $stable(ib_full) && $stable(ob_aux)))
      else $error("a_r11_status_read_quiet");
   // R5: bit 3 tracks the port of the last write
   a_r5_cmd_bit: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> host_rdata[ST_CMD] == $past(host_sel_cmd) || !host_sel_cmd)
      else $error("a_r5_cmd_bit");
   // R1: top status bit never set
   a_r1_bit7_low: assert property (@(posedge clk) disable iff (!rst_n)
      host_sel_cmd |-> !host_rdata[ST_W-1])
      else $error("a_r1_bit7_low");
endmodule

// File: tb/kbc_host_port_tb_top.sv
module kbc_host_port_tb_top;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_rd = 0, host_wr = 0, host_sel_cmd = 1;
   logic [W-1:0] host_wdata = '0;
   logic [W-1:0] host_rdata;
   logic         dev_load = 0, dev_is_aux = 0;
   logic [W-1:0] dev_data = '0;
   logic         dev_stall;
   logic         ctl_take = 0;
   logic [W-1:0] ctl_byte;
   logic         ctl_is_cmd, ctl_pending;
   logic         sys_flag_we = 0, sys_flag_in = 0, inhibit_in = 0;
   logic         timeout_set = 0, timeout_clr = 0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   kbc_host_port #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_rd(host_rd), .host_wr(host_wr), .host_sel_cmd(host_sel_cmd),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dev_load(dev_load), .dev_is_aux(dev_is_aux), .dev_data(dev_data),
      .dev_stall(dev_stall),
      .ctl_take(ctl_take), .ctl_byte(ctl_byte), .ctl_is_cmd(ctl_is_cmd),
      .ctl_pending(ctl_pending),
      .sys_flag_we(sys_flag_we), .sys_flag_in(sys_flag_in),
      .inhibit_in(inhibit_in),
      .timeout_set(timeout_set), .timeout_clr(timeout_clr)
   );

   task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic status(output logic [W-1:0] s);
      host_sel_cmd = 1'b1;
      #1;
      s = host_rdata;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [W-1:0] s;
      status(s);
      check("R1 reset status", s, 8'h00);
      check("R1 reset pending", {7'd0, ctl_pending}, 8'h00);
   endtask

   task automatic t_load_read(logic aux, logic [W-1:0] b);
      logic [W-1:0] s;
      tick();
      dev_load = 1; dev_is_aux = aux; dev_data = b;
      tick();
      dev_load = 0;
      status(s);
      check("R2 bit0 set", {7'd0, s[0]}, 8'h01);
      check("R2 bit5 tag", {7'd0, s[5]}, {7'd0, aux});
      host_sel_cmd = 0; host_rd = 1;
      #1;
      check("R3 data read", host_rdata, b);
      tick();
      host_rd = 0;
      status(s);
      check("R3 bits0/5 cleared", s & 8'h21, 8'h00);
   endtask

   task automatic t_stall();
      logic [W-1:0] s;
      tick();
      dev_load = 1; dev_is_aux = 0; dev_data = 8'h1C;
      tick();
      dev_is_aux = 1; dev_data = 8'h77;
      #1;
      check("R4 stall high", {7'd0, dev_stall}, 8'h01);
      tick();
      dev_load = 0;
      status(s);
      check("R4 tag kept", {7'd0, s[5]}, 8'h00);
      host_sel_cmd = 0;
      #1;
      check("R4 byte kept", host_rdata, 8'h1C);
      host_rd = 1;
      tick();
      host_rd = 0;
      #1;
      check("R4 stall low when empty", {7'd0, dev_stall}, 8'h00);
   endtask

   task automatic hwrite(logic cmd, logic [W-1:0] b, logic take);
      tick();
      host_wr = 1; host_sel_cmd = cmd; host_wdata = b; ctl_take = take;
      tick();
      host_wr = 0; ctl_take = 0;
   endtask

   task automatic t_host_write();
      logic [W-1:0] s;
      hwrite(0, 8'hAA, 0);
      status(s);
      check("R5 data write bit1", {7'd0, s[1]}, 8'h01);
      check("R5 data write bit3", {7'd0, s[3]}, 8'h00);
      check("R5 byte", ctl_byte, 8'hAA);
      hwrite(1, 8'hBB, 1);
      status(s);
      check("R7 collision bit1", {7'd0, s[1]}, 8'h01);
      check("R5 cmd write bit3", {7'd0, s[3]}, 8'h01);
      check("R7 collision byte", ctl_byte, 8'hBB);
      tick();
      ctl_take = 1;
      tick();
      ctl_take = 0;
      status(s);
      check("R7 take clears bit1", {7'd0, s[1]}, 8'h00);
      check("R7 bit3 kept", {7'd0, s[3]}, 8'h01);
      hwrite(0, 8'h11, 0);
      hwrite(1, 8'h22, 0);
      check("R6 overwrite byte", ctl_byte, 8'h22);
      check("R6 overwrite cmd", {7'd0, ctl_is_cmd}, 8'h01);
   endtask

   task automatic t_sys();
      logic [W-1:0] s;
      tick();
      sys_flag_we = 1; sys_flag_in = 1;
      tick();
      sys_flag_we = 0; sys_flag_in = 0;
      tick();
      status(s);
      check("R8 sys set and held", {7'd0, s[2]}, 8'h01);
      sys_flag_we = 1;
      tick();
      sys_flag_we = 0;
      status(s);
      check("R8 sys cleared", {7'd0, s[2]}, 8'h00);
   endtask

   task automatic t_inhibit();
      logic [W-1:0] s;
      tick();
      inhibit_in = 1;
      tick();
      status(s);
      check("R9 one edge", {7'd0, s[4]}, 8'h00);
      tick();
      status(s);
      check("R9 two edges", {7'd0, s[4]}, 8'h01);
      inhibit_in = 0;
      tick(); tick();
      status(s);
      check("R9 back low", {7'd0, s[4]}, 8'h00);
   endtask

   task automatic t_timeout();
      logic [W-1:0] s;
      tick();
      timeout_set = 1;
      tick();
      timeout_set = 0;
      status(s);
      check("R10 set", {7'd0, s[6]}, 8'h01);
      timeout_set = 1; timeout_clr = 1;
      tick();
      timeout_set = 0; timeout_clr = 0;
      status(s);
      check("R10 set wins", {7'd0, s[6]}, 8'h01);
      check("R1 bit7 low", {7'd0, s[7]}, 8'h00);
      timeout_clr = 1;
      tick();
      timeout_clr = 0;
      status(s);
      check("R10 clear", {7'd0, s[6]}, 8'h00);
   endtask

   task automatic t_status_quiet();
      logic [W-1:0] s0, s1;
      tick();
      dev_load = 1; dev_is_aux = 1; dev_data = 8'h5A;
      tick();
      dev_load = 0;
      status(s0);
      host_rd = 1;
      tick();
      host_rd = 0;
      status(s1);
      check("R11 status read quiet", s1 & 8'h23, s0 & 8'h23);
      check("R11 obf/aux/ibf state", s1 & 8'h23, 8'h23);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      t_load_read(1'b0, 8'h3C);
      t_load_read(1'b1, 8'hE5);
      t_stall();
      t_host_write();
      t_sys();
      t_inhibit();
      t_timeout();
      t_status_quiet();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule